// File: doc/BRIEF.md
# Two-Bus Dominant Relay Core

This block is the digital heart of a hub that joins two CAN bus segments to one local controller. It takes four sources of dominant level: a local transmit bit, an external transmit bit and the two bus receiver bits. Any dominant from a local source goes out on both bus lines. A dominant seen on one bus goes out on the other bus. Every source, gated and timed, sets the local receive output. Neither bus has priority over the other.

Each source passes through its own dominant timeout, so that a stuck input cannot hold the buses dominant for good. Because a dominant is copied both ways, the echo of a driven bus would come straight back and lock both buses dominant. To stop this, reception from a bus is masked while the block drives that bus dominant, and for a fixed number of cycles afterwards. A power-on-reset input holds the block in a quiet state. An over-temperature input turns off only the two bus drives.

Top module: `can_dual_relay_core`

## Requirements
- R1: Every level port uses 0 for dominant and 1 for recessive. After rst_n is sampled low, all three outputs are 1.
- R2: While rx1_dis_i (or rx2_dis_i) is 1, that bus's receiver bit counts as recessive, whatever the bus level is.
- R3: Each of the four sources has its own timer. A source that stays dominant is seen as dominant for exactly TIMEOUT_CYC cycles and then as recessive. The timer restarts once the source goes back to recessive.
- R4: A dominant on tx_local_i drives both bus outputs and rx_local_o dominant at the next clock edge. The same holds for tx_ext_i three edges after it changes, because of a two-stage synchroniser.
- R5: A dominant received on one bus drives the other bus output dominant three edges later. It never drives the output of the bus it came from.
- R6: While a bus output is dominant, reception from that bus is ignored. When all sources are released, both buses return to recessive and stay there (no interlock).
- R7: Reception from a bus stays ignored for HOLD_CYC cycles after that bus output has returned to recessive.
- R8: rx_local_o is registered. It is dominant whenever a timed, unmasked source among the local transmit, the external transmit, bus 1 and bus 2 is dominant.
- R9: While por_i is 1, every timer is cleared and all three outputs are 1 from the next edge on. After por_i is released, a source that is held dominant gets a full TIMEOUT_CYC window again.
- R10: While overtemp_i is 1, both bus outputs are 1 from the next edge on. Reception, the timers and rx_local_o keep working.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| por_i | input | 1 | Power-on-reset hold, active high |
| overtemp_i | input | 1 | Over-temperature flag, forces the bus drives off |
| tx_local_i | input | 1 | Local transmit bit, synchronous to clk |
| tx_ext_i | input | 1 | External transmit bit, asynchronous |
| bus1_rx_i | input | 1 | Bus 1 receiver bit, asynchronous |
| bus2_rx_i | input | 1 | Bus 2 receiver bit, asynchronous |
| rx1_dis_i | input | 1 | 1 disables the bus 1 receiver |
| rx2_dis_i | input | 1 | 1 disables the bus 2 receiver |
| bus1_tx_o | output | 1 | Bus 1 drive, 0 means dominant |
| bus2_tx_o | output | 1 | Bus 2 drive, 0 means dominant |
| rx_local_o | output | 1 | Local receive bit |

## Verification
The hardest case to reach is the hold-off window. This is the short span after a bus drive ends, when the delayed echo of that bus is still arriving and must not be copied back. Testing it needs real feedback, so the bench wires each bus receiver input to the AND of its own bus output and an outside dominant source. Every relayed dominant then produces a true echo that is delayed by the synchroniser. Random short pulses on the outside sources, the transmit inputs, the enables, POR and over-temperature then fall inside and across that window many times. A cycle model checks each output on every cycle.

// File: rtl/crl_pkg.sv
// Shared constants for the two-bus dominant relay core.
// Assumes: dominant is logic 0 on every level signal.
package crl_pkg;
    localparam logic LVL_DOM = 1'b0;
    localparam logic LVL_REC = 1'b1;
    localparam int   NUM_SRC = 4;
    localparam int   NUM_BUS = 2;
    localparam int   NUM_ASYNC = 3;
    // Source slots in the timed source vector.
    localparam int   SRC_LOCAL = 0;
    localparam int   SRC_EXT   = 1;
    localparam int   SRC_BUS1  = 2;
    localparam int   SRC_BUS2  = 3;
endpackage

// File: rtl/crl_sync2.sv
// Two-flip-flop synchroniser for a vector of asynchronous level bits.
// Assumes: the idle level is recessive, so the stages clear to all ones.
module crl_sync2 #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Shift each bit through two stages; clear to recessive.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            stage1_q <= '1;
            stage2_q <= '1;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;
endmodule

// File: rtl/crl_dom_timer.sv
// Dominant timeout for one source. It passes a dominant through for at
// most LIMIT cycles, then shows recessive until the input goes recessive.
// Assumes: in_i is synchronous to clk and LIMIT >= 1.
module crl_dom_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic clr_n,
    input  logic in_i,
    output logic out_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    // Count dominant cycles and saturate at the limit; restart on recessive.
    always_ff @(posedge clk) begin
        if (!clr_n || in_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign out_o = in_i | (cnt_q == CNT_MAX);

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!clr_n)
        cnt_q <= CNT_MAX);

    assert_restart_R3: assert property (@(posedge clk) disable iff (!clr_n)
        in_i |=> (cnt_q == '0));
endmodule

// File: rtl/crl_fb_suppress.sv
// Feedback suppression for one bus. Reception is masked while the bus is
// driven dominant and for HOLD_CYC cycles after the drive returns recessive.
// Assumes: drive_i is the registered bus output.
module crl_fb_suppress #(
    parameter int HOLD_CYC = 4
) (
    input  logic clk,
    input  logic clr_n,
    input  logic drive_i,
    output logic mask_o
);
    localparam int HW = (HOLD_CYC < 1) ? 1 : $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD_CYC);

    logic [HW-1:0] hold_q;

    // Reload the hold-off while driving; count down once the drive stops.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            hold_q <= '0;
        end else if (!drive_i) begin
            hold_q <= HOLD_LOAD;
        end else if (hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
        end
    end

    assign mask_o = ~drive_i | (hold_q != '0);

    generate
        if (HOLD_CYC > 0) begin : g_hold_chk
            assert_mask_after_release_R7: assert property (@(posedge clk)
                disable iff (!clr_n)
                ($rose(drive_i) && $past(clr_n)) |-> mask_o);
        end
    endgenerate
endmodule

// File: rtl/can_dual_relay_core.sv
// Two-bus dominant relay core. It merges local and external transmit bits
// with two bus receiver bits, and copies dominants between the buses with
// no priority. Each source has a timeout, and feedback suppression stops
// the buses from locking each other dominant.
// Assumes: tx_local_i is synchronous to clk; the other data inputs are
// asynchronous; the enables, por_i and overtemp_i are quasi-static levels.
module can_dual_relay_core #(
    parameter int TIMEOUT_CYC = 64,
    parameter int HOLD_CYC    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic por_i,
    input  logic overtemp_i,
    input  logic tx_local_i,
    input  logic tx_ext_i,
    input  logic bus1_rx_i,
    input  logic bus2_rx_i,
    input  logic rx1_dis_i,
    input  logic rx2_dis_i,
    output logic bus1_tx_o,
    output logic bus2_tx_o,
    output logic rx_local_o
);
    import crl_pkg::*;

    logic                 clr_n;
    logic [NUM_ASYNC-1:0] async_raw;
    logic [NUM_ASYNC-1:0] async_syn;
    logic [NUM_SRC-1:0]   src_raw;
    logic [NUM_SRC-1:0]   src_timed;
    logic [NUM_BUS-1:0]   drive_q;
    logic [NUM_BUS-1:0]   drive_next;
    logic [NUM_BUS-1:0]   rx_mask;
    logic [NUM_BUS-1:0]   rx_open;
    logic                 local_lvl;
    logic                 rx_q;

    assign clr_n = rst_n & ~por_i;

    // Bring the asynchronous bits into the clock domain.
    assign async_raw = {bus2_rx_i, bus1_rx_i, tx_ext_i};

    crl_sync2 #(.WIDTH(NUM_ASYNC)) u_sync (
        .clk   (clk),
        .clr_n (clr_n),
        .d_i   (async_raw),
        .q_o   (async_syn)
    );

    // Gather the sources; a disabled receiver reads as recessive.
    always_comb begin
        src_raw            = '1;
        src_raw[SRC_LOCAL] = tx_local_i;
        src_raw[SRC_EXT]   = async_syn[0];
        src_raw[SRC_BUS1]  = async_syn[1] | rx1_dis_i;
        src_raw[SRC_BUS2]  = async_syn[2] | rx2_dis_i;
    end

    generate
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_timer
            crl_dom_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
                .clk   (clk),
                .clr_n (clr_n),
                .in_i  (src_raw[s]),
                .out_o (src_timed[s])
            );
        end
        for (genvar b = 0; b < NUM_BUS; b++) begin : g_supp
            crl_fb_suppress #(.HOLD_CYC(HOLD_CYC)) u_supp (
                .clk     (clk),
                .clr_n   (clr_n),
                .drive_i (drive_q[b]),
                .mask_o  (rx_mask[b])
            );
        end
    endgenerate

    // Timed bus receptions with the feedback mask applied.
    assign rx_open[0] = src_timed[SRC_BUS1] | rx_mask[0];
    assign rx_open[1] = src_timed[SRC_BUS2] | rx_mask[1];
    assign local_lvl  = src_timed[SRC_LOCAL] & src_timed[SRC_EXT];

    // Each bus takes the local sources and the opposite bus; heat blocks both.
    always_comb begin
        drive_next[0] = (local_lvl & rx_open[1]) | overtemp_i;
        drive_next[1] = (local_lvl & rx_open[0]) | overtemp_i;
    end

    // Output registers, held recessive in reset and power-on-reset.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            drive_q <= {NUM_BUS{LVL_REC}};
            rx_q    <= LVL_REC;
        end else begin
            drive_q <= drive_next;
            rx_q    <= local_lvl & rx_open[0] & rx_open[1];
        end
    end

    assign bus1_tx_o  = drive_q[0];
    assign bus2_tx_o  = drive_q[1];
    assign rx_local_o = rx_q;

    assert_por_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        por_i |=> (bus1_tx_o && bus2_tx_o && rx_local_o));

    assert_overtemp_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overtemp_i |=> (bus1_tx_o && bus2_tx_o));

    assert_local_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_local_i && !por_i && !overtemp_i && $past(tx_local_i))
        |=> (!bus1_tx_o && !bus2_tx_o && !rx_local_o));
endmodule

// File: tb/can_dual_relay_core_tb.sv
`timescale 1ns/1ps
module can_dual_relay_core_tb_top;
    localparam int TO = 12;
    localparam int HO = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic por = 1'b0;
    logic overtemp = 1'b0;
    logic tx_local = 1'b1;
    logic tx_ext = 1'b1;
    logic ext1 = 1'b1;
    logic ext2 = 1'b1;
    logic dis1 = 1'b0;
    logic dis2 = 1'b0;
    logic bus1_rx;
    logic bus2_rx;
    logic bus1_tx_o;
    logic bus2_tx_o;
    logic rx_local_o;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R1";

    always #2 clk = ~clk;

    // Each bus line is the wired AND of the hub drive and an outside node.
    assign bus1_rx = bus1_tx_o & ext1;
    assign bus2_rx = bus2_tx_o & ext2;

    can_dual_relay_core #(.TIMEOUT_CYC(TO), .HOLD_CYC(HO)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .por_i      (por),
        .overtemp_i (overtemp),
        .tx_local_i (tx_local),
        .tx_ext_i   (tx_ext),
        .bus1_rx_i  (bus1_rx),
        .bus2_rx_i  (bus2_rx),
        .rx1_dis_i  (dis1),
        .rx2_dis_i  (dis2),
        .bus1_tx_o  (bus1_tx_o),
        .bus2_tx_o  (bus2_tx_o),
        .rx_local_o (rx_local_o)
    );

    // Requirement model state.
    int   m_cnt [4];
    int   m_hold [2];
    logic [2:0] m_s1 = '1;
    logic [2:0] m_s2 = '1;
    logic m_b1 = 1'b1;
    logic m_b2 = 1'b1;
    logic m_rx = 1'b1;

    function automatic logic timed(logic lvl, int cnt);
        return lvl | (cnt >= TO);
    endfunction

    // Cycle model built from R2..R10.
    always @(posedge clk) begin : model
        logic [3:0] src;
        logic [3:0] t;
        logic u1, u2, loc, nb1, nb2, nrx;
        if (!rst_n || por) begin
            for (int i = 0; i < 4; i++) m_cnt[i] = 0;
            m_hold[0] = 0; m_hold[1] = 0;
            m_s1 = '1; m_s2 = '1;
            m_b1 = 1'b1; m_b2 = 1'b1; m_rx = 1'b1;
        end else begin
            src = {m_s2[2] | dis2, m_s2[1] | dis1, m_s2[0], tx_local};
            for (int i = 0; i < 4; i++) t[i] = timed(src[i], m_cnt[i]);
            u1  = t[2] | !m_b1 | (m_hold[0] != 0);
            u2  = t[3] | !m_b2 | (m_hold[1] != 0);
            loc = t[0] & t[1];
            nb1 = (loc & u2) | overtemp;
            nb2 = (loc & u1) | overtemp;
            nrx = loc & u1 & u2;
            for (int i = 0; i < 4; i++)
                m_cnt[i] = src[i] ? 0 : ((m_cnt[i] < TO) ? m_cnt[i] + 1 : TO);
            m_hold[0] = !m_b1 ? HO : ((m_hold[0] > 0) ? m_hold[0] - 1 : 0);
            m_hold[1] = !m_b2 ? HO : ((m_hold[1] > 0) ? m_hold[1] - 1 : 0);
            m_s2 = m_s1;
            m_s1 = {bus2_rx, bus1_rx, tx_ext};
            m_b1 = nb1; m_b2 = nb2; m_rx = nrx;
        end
    end

    task automatic check3(string tag, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s {bus1,bus2,rx}: actual=%b expected=%b at %0t",
                     tag, act, exp, $time);
        end
    endtask

    task automatic check_int(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Advance to the next falling edge and compare against the model.
    task automatic cyc();
        @(negedge clk);
        check3({cur_tag, " model"}, {bus1_tx_o, bus2_tx_o, rx_local_o},
               {m_b1, m_b2, m_rx});
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    function automatic logic [2:0] outs();
        return {bus1_tx_o, bus2_tx_o, rx_local_o};
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        int n;
        void'($urandom(32'd20240611));
        @(negedge clk);
        idle(3);
        rst_n = 1'b1;
        cyc();
        // R1: reset state is all recessive.
        check3("R1 reset", outs(), 3'b111);

        // R4: local transmit reaches both buses and the receive output in one edge.
        cur_tag = "R4";
        tx_local = 1'b0;
        cyc();
        check3("R4 local dominant", outs(), 3'b000);

        // R3: the timeout cuts the dominant after TO cycles.
        cur_tag = "R3";
        n = 1;
        for (int i = 0; i < 3 * TO; i++) begin
            cyc();
            if (!rx_local_o) n++;
        end
        check_int("R3 timeout length", n, TO);
        check3("R3 after timeout", outs(), 3'b111);
        tx_local = 1'b1;
        cyc();
        tx_local = 1'b0;
        cyc();
        check3("R3 timer restart", outs(), 3'b000);
        tx_local = 1'b1;
        idle(2 * TO);

        // R8: the external transmit goes through the synchroniser.
        cur_tag = "R8";
        tx_ext = 1'b0;
        idle(3);
        check3("R8 external dominant", outs(), 3'b000);
        tx_ext = 1'b1;
        idle(2 * TO);

        // R5: a bus 1 dominant goes to bus 2 only.
        cur_tag = "R5";
        ext1 = 1'b0;
        idle(3);
        check3("R5 bus1 to bus2", outs(), 3'b100);
        // R6: no interlock after release.
        cur_tag = "R6";
        ext1 = 1'b1;
        idle(20);
        check3("R6 no interlock 1", outs(), 3'b111);
        cur_tag = "R5";
        ext2 = 1'b0;
        idle(3);
        check3("R5 bus2 to bus1", outs(), 3'b010);
        cur_tag = "R6";
        ext2 = 1'b1;
        idle(20);
        check3("R6 no interlock 2", outs(), 3'b111);

        // R2: a disabled receiver ignores the bus.
        cur_tag = "R2";
        dis1 = 1'b1;
        ext1 = 1'b0;
        n = 0;
        for (int i = 0; i < 10; i++) begin
            cyc();
            if (outs() != 3'b111) n++;
        end
        check_int("R2 disabled receiver cycles not recessive", n, 0);
        ext1 = 1'b1;
        idle(4);
        dis1 = 1'b0;
        idle(4);

        // R7: an echo inside the hold-off is not copied back.
        cur_tag = "R7";
        ext1 = 1'b0;
        idle(4);
        ext1 = 1'b1;
        idle(3);
        ext2 = 1'b0;
        cyc();
        ext2 = 1'b1;
        n = 0;
        for (int i = 0; i < 8; i++) begin
            cyc();
            if (!bus1_tx_o) n++;
        end
        check_int("R7 bus1 driven during hold-off", n, 0);
        idle(10);

        // R9: power-on-reset quiets the block and clears the timers.
        cur_tag = "R9";
        tx_local = 1'b0;
        por = 1'b1;
        idle(3 * TO);
        check3("R9 por outputs", outs(), 3'b111);
        por = 1'b0;
        n = 0;
        for (int i = 0; i < 3 * TO; i++) begin
            cyc();
            if (!rx_local_o) n++;
        end
        check_int("R9 fresh timeout after por", n, TO);
        tx_local = 1'b1;
        idle(10);

        // R10: over-temperature drops only the bus drives.
        cur_tag = "R10";
        overtemp = 1'b1;
        tx_local = 1'b0;
        cyc();
        check3("R10 overtemp", outs(), 3'b110);
        tx_local = 1'b1;
        idle(3);
        overtemp = 1'b0;
        idle(10);

        // Random mix, checked every cycle by the model (R4..R10).
        cur_tag = "R4-mix R5 R6 R7 R8 R9 R10";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 11) == 0) tx_local = ~tx_local;
            if ($urandom_range(0, 11) == 0) tx_ext = ~tx_ext;
            if ($urandom_range(0, 7) == 0) ext1 = ~ext1;
            if ($urandom_range(0, 7) == 0) ext2 = ~ext2;
            if ($urandom_range(0, 99) == 0) dis1 = ~dis1;
            if ($urandom_range(0, 99) == 0) dis2 = ~dis2;
            if ($urandom_range(0, 149) == 0) overtemp = ~overtemp;
            por = ($urandom_range(0, 299) == 0);
            cyc();
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule